// File: doc/BRIEF.md
# Register stack flush sequencer

This block empties the dirty part of a register stack into its backing store in memory. It holds three pieces of state: a store pointer (a doubleword address), a count of dirty stacked registers, and the physical index of the oldest dirty register. Pipeline logic loads these while the block is idle. A flush command then spills every dirty register in order through a store port that carries one request at a time, with an acknowledge. Register values and their NaT bits come from a combinational read port that the block indexes.

Every doubleword slot whose address bits [8:3] are all ones is a collection slot. At that slot the block writes out a 64-bit NaT accumulator in place of a register. The accumulator gathers the NaT bit of each spilled register at the bit position given by that register's slot. The block also computes the stack top pointer continuously from the store pointer and the dirty count. When the flush ends, the store pointer equals that top pointer and a one-cycle done pulse is raised.

Top module: `rse_flush_seq`

## Requirements
- R1: After reset the block is idle, with `st_req`, `busy` and `done` low, and with store pointer, dirty count, base index and NaT accumulator all zero.
- R2: While idle and with no flush command, `ld_en` loads the store pointer from `ld_ptr` with bits [2:0] forced to zero, the dirty count from `ld_cnt` and the base index from `ld_base`. If `flush_cmd` and `ld_en` are both high in the same cycle, the flush wins and the load is dropped.
- R3: A flush with a nonzero dirty count raises `busy` and `st_req` in the next cycle. `st_addr` equals the store pointer. Request, address and data stay stable until `st_ack`, and each acknowledge advances the store pointer by 8.
- R4: At a register slot (address bits [8:3] not all ones), `st_data` is `rd_data` for index `rd_idx`. `rd_idx` is the base index. On acknowledge, the dirty count decrements by one and the base index advances by one, wrapping from NPHYS-1 to 0.
- R5: On acknowledge of a register slot, accumulator bit number address[8:3] takes `rd_nat`. No other accumulator bit changes.
- R6: At a collection slot (address bits [8:3] = 63), `st_data` is the accumulator. On acknowledge the accumulator clears, while the dirty count and base index stay unchanged.
- R7: The flush ends on the acknowledge after which the dirty count is zero and the next slot is not a collection slot. `busy` falls and `done` pulses for one cycle in the next cycle. At that point the store pointer equals `top_ptr` and the dirty count is zero.
- R8: `top_ptr` equals store_ptr + 8*(cnt + (store_ptr[8:3] + cnt)/63), and it stays constant during a flush.
- R9: A flush command while idle with a dirty count of zero pulses `done` in the next cycle and issues no store.
- R10: `flush_cmd` and `ld_en` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load pointer, count and base |
| ld_ptr | input | ADDR_W | Store pointer value to load |
| ld_cnt | input | CNT_W | Dirty count to load |
| ld_base | input | IDX_W | Physical index of the oldest dirty register |
| flush_cmd | input | 1 | Start a flush |
| rd_idx | output | IDX_W | Register file read index |
| rd_data | input | 64 | Register value at `rd_idx` |
| rd_nat | input | 1 | NaT bit of the register at `rd_idx` |
| st_req | output | 1 | Store request |
| st_addr | output | ADDR_W | Store address |
| st_data | output | 64 | Store data |
| st_ack | input | 1 | Store accepted |
| busy | output | 1 | Flush in progress |
| done | output | 1 | One-cycle completion pulse |
| store_ptr | output | ADDR_W | Current store pointer |
| dirty_cnt | output | CNT_W | Current dirty count |
| nat_acc | output | 64 | NaT accumulator |
| top_ptr | output | ADDR_W | Derived stack top pointer |

## Verification
The assertions assume that `st_ack` is raised only while `st_req` is high. They also assume that a loaded pointer never sits on a collection slot, since the top pointer never does either. The stimulus drives the acknowledge from the observed request, with random delays, and loads only pointers whose bits [8:3] differ from 63. It reaches both corner slots: a start at slot 62 with one register, and a long run that crosses two collections and wraps the base index.

// File: rtl/rse_flush_pkg.sv
package rse_flush_pkg;
  localparam int WORD_W  = 64;
  localparam int SLOT_LO = 3;
  localparam int SLOT_W  = 6;
  localparam int COLL_SLOT = (1 << SLOT_W) - 1;

  typedef enum logic {
    FL_IDLE  = 1'b0,
    FL_SPILL = 1'b1
  } fl_state_e;
endpackage

// File: rtl/rse_top_calc.sv
module rse_top_calc
  import rse_flush_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] top
);
  localparam int SW = CNT_W + 2;

  logic [SW-1:0] sum_w, cross_w, total_w;

  always_comb begin
    sum_w   = SW'(cnt) + SW'(ptr[SLOT_LO +: SLOT_W]);
    cross_w = sum_w / SW'(COLL_SLOT);
    total_w = SW'(cnt) + cross_w;
    top     = ptr + (ADDR_W'(total_w) << SLOT_LO);
  end
endmodule

// File: rtl/rse_nat_acc.sv
module rse_nat_acc
  import rse_flush_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              file_en,
  input  logic [SLOT_W-1:0] file_pos,
  input  logic              file_bit,
  input  logic              clear_en,
  output logic [WORD_W-1:0] acc
);
  logic [WORD_W-1:0] acc_q, acc_d;
  logic              acc_en;

  always_comb begin
    acc_en = file_en | clear_en;
    acc_d  = acc_q;
    if (clear_en) acc_d = '0;
    else if (file_en) acc_d[file_pos] = file_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc = acc_q;

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |=> (acc == '0));

  p_file_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (file_en && !clear_en) |=> (acc[$past(file_pos)] == $past(file_bit)));
endmodule

// File: rtl/rse_flush_ctrl.sv
module rse_flush_ctrl
  import rse_flush_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int NPHYS  = 96,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_ptr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic [IDX_W-1:0]  ld_base,
  input  logic              flush_cmd,
  input  logic              st_ack,
  output logic              st_req,
  output logic [ADDR_W-1:0] st_addr,
  output logic              coll_slot,
  output logic              file_en,
  output logic              clear_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] store_ptr,
  output logic [CNT_W-1:0]  dirty_cnt
);
  fl_state_e         state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  base_q, base_d;
  logic              done_q, done_d;
  logic              ptr_en, cnt_en, base_en;
  logic [SLOT_W-1:0] slot;
  logic              take;
  logic              fin;
  logic [CNT_W-1:0]  cnt_after;

  assign slot      = ptr_q[SLOT_LO +: SLOT_W];
  assign coll_slot = (slot == SLOT_W'(COLL_SLOT));
  assign take      = (state_q == FL_SPILL) && st_ack;
  assign cnt_after = coll_slot ? cnt_q : cnt_q - CNT_W'(1);
  // the slot after 62 is a collection slot, which must still be written
  assign fin       = (cnt_after == '0) && (slot != SLOT_W'(COLL_SLOT - 1));

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    ptr_en  = 1'b0;
    cnt_en  = 1'b0;
    base_en = 1'b0;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    base_d  = base_q;
    case (state_q)
      FL_IDLE: begin
        if (flush_cmd) begin
          if (cnt_q == '0) done_d = 1'b1;
          else state_d = FL_SPILL;
        end else if (ld_en) begin
          ptr_en  = 1'b1;
          cnt_en  = 1'b1;
          base_en = 1'b1;
          ptr_d   = ld_ptr & ~ADDR_W'(7);
          cnt_d   = ld_cnt;
          base_d  = ld_base;
        end
      end
      FL_SPILL: begin
        if (st_ack) begin
          ptr_en = 1'b1;
          ptr_d  = ptr_q + ADDR_W'(8);
          if (!coll_slot) begin
            cnt_en  = 1'b1;
            base_en = 1'b1;
            cnt_d   = cnt_after;
            base_d  = (base_q == IDX_W'(NPHYS - 1)) ? '0 : base_q + IDX_W'(1);
          end
          if (fin) begin
            state_d = FL_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = FL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FL_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  assign st_req    = (state_q == FL_SPILL);
  assign st_addr   = ptr_q;
  assign file_en   = take && !coll_slot;
  assign clear_en  = take && coll_slot;
  assign rd_idx    = base_q;
  assign busy      = st_req;
  assign done      = done_q;
  assign store_ptr = ptr_q;
  assign dirty_cnt = cnt_q;

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !st_ack) |=> (st_req && $stable(st_addr)));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && st_ack) |=> (store_ptr == $past(store_ptr) + ADDR_W'(8)));

  p_cnt_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && st_ack && !coll_slot) |=> (dirty_cnt == $past(dirty_cnt) - CNT_W'(1)));

  p_cnt_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && st_ack && coll_slot) |=> $stable(dirty_cnt) && $stable(rd_idx));

  p_zero_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && flush_cmd && dirty_cnt == '0) |=> (done && !st_req));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !st_ack) |=> ($stable(store_ptr) && $stable(dirty_cnt)));
endmodule

// File: rtl/rse_flush_seq.sv
module rse_flush_seq
  import rse_flush_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int NPHYS  = 96,
  localparam int IDX_W = $clog2(NPHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_ptr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic [IDX_W-1:0]  ld_base,
  input  logic              flush_cmd,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              rd_nat,
  output logic              st_req,
  output logic [ADDR_W-1:0] st_addr,
  output logic [WORD_W-1:0] st_data,
  input  logic              st_ack,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] store_ptr,
  output logic [CNT_W-1:0]  dirty_cnt,
  output logic [WORD_W-1:0] nat_acc,
  output logic [ADDR_W-1:0] top_ptr
);
  logic coll_slot, file_en, clear_en;

  rse_flush_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NPHYS(NPHYS), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_ptr(ld_ptr), .ld_cnt(ld_cnt),
    .ld_base(ld_base), .flush_cmd(flush_cmd), .st_ack(st_ack), .st_req(st_req),
    .st_addr(st_addr), .coll_slot(coll_slot), .file_en(file_en), .clear_en(clear_en),
    .rd_idx(rd_idx), .busy(busy), .done(done), .store_ptr(store_ptr),
    .dirty_cnt(dirty_cnt)
  );

  rse_nat_acc u_acc (
    .clk(clk), .rst_n(rst_n), .file_en(file_en),
    .file_pos(store_ptr[SLOT_LO +: SLOT_W]), .file_bit(rd_nat),
    .clear_en(clear_en), .acc(nat_acc)
  );

  rse_top_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_top (
    .ptr(store_ptr), .cnt(dirty_cnt), .top(top_ptr)
  );

  assign st_data = coll_slot ? nat_acc : rd_data;

  p_done_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (store_ptr == top_ptr && dirty_cnt == '0 && !busy));

  p_top_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(top_ptr));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !st_ack) |=> $stable(st_data));
endmodule

// File: tb/rse_flush_seq_bench.sv
module rse_flush_seq_bench;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;
  localparam int NPHYS  = 96;
  localparam int IDX_W  = $clog2(NPHYS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              ld_en = 1'b0, flush_cmd = 1'b0, st_ack = 1'b0;
  logic [ADDR_W-1:0] ld_ptr = '0;
  logic [CNT_W-1:0]  ld_cnt = '0;
  logic [IDX_W-1:0]  ld_base = '0;
  logic [IDX_W-1:0]  rd_idx;
  logic [63:0]       rd_data, st_data, nat_acc;
  logic              rd_nat, st_req, busy, done;
  logic [ADDR_W-1:0] st_addr, store_ptr, top_ptr;
  logic [CNT_W-1:0]  dirty_cnt;

  logic [63:0] regv [NPHYS];
  logic        natv [NPHYS];
  assign rd_data = regv[rd_idx];
  assign rd_nat  = natv[rd_idx];

  rse_flush_seq u_rse_flush_seq (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_ptr(ld_ptr), .ld_cnt(ld_cnt),
    .ld_base(ld_base), .flush_cmd(flush_cmd), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_nat(rd_nat), .st_req(st_req), .st_addr(st_addr), .st_data(st_data),
    .st_ack(st_ack), .busy(busy), .done(done), .store_ptr(store_ptr),
    .dirty_cnt(dirty_cnt), .nat_acc(nat_acc), .top_ptr(top_ptr)
  );

  int checks = 0, errors = 0;
  int ack_pct = 40;
  bit cmp_on = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          busy_m = 0, done_m = 0;
  logic [31:0] ptr_m = '0;
  int          cnt_m = 0, base_m = 0;
  logic [63:0] acc_m = '0;

  always @(posedge clk) begin
    int s;
    done_m = 0;
    if (!rst_n) begin
      busy_m = 0; ptr_m = '0; cnt_m = 0; base_m = 0; acc_m = '0;
    end else if (!busy_m) begin
      if (flush_cmd) begin
        if (cnt_m == 0) done_m = 1; else busy_m = 1;
      end else if (ld_en) begin
        ptr_m = {ld_ptr[31:3], 3'b000}; cnt_m = int'(ld_cnt); base_m = int'(ld_base);
      end
    end else if (st_ack) begin
      s = int'(ptr_m[8:3]);
      if (s == 63) acc_m = '0;
      else begin
        acc_m[s] = natv[base_m];
        cnt_m--;
        base_m = (base_m + 1) % NPHYS;
      end
      ptr_m = ptr_m + 32'd8;
      if (cnt_m == 0 && ptr_m[8:3] != 6'd63) begin busy_m = 0; done_m = 1; end
    end
  end

  function automatic logic [31:0] top_m();
    int s = int'(ptr_m[8:3]);
    return ptr_m + 32'(8 * (cnt_m + (s + cnt_m) / 63));
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R3 busy", 64'(busy), 64'(busy_m));
      chk("R3 st_req", 64'(st_req), 64'(busy_m));
      chk("R3 store_ptr", 64'(store_ptr), 64'(ptr_m));
      chk("R4 dirty_cnt", 64'(dirty_cnt), 64'(cnt_m));
      chk("R4 rd_idx", 64'(rd_idx), 64'(base_m));
      chk("R5 nat_acc", nat_acc, acc_m);
      chk("R7 done", 64'(done), 64'(done_m));
      chk("R8 top_ptr", 64'(top_ptr), 64'(top_m()));
      if (busy_m) begin
        chk("R3 st_addr", 64'(st_addr), 64'(ptr_m));
        if (ptr_m[8:3] == 6'd63) chk("R6 st_data", st_data, acc_m);
        else chk("R4 st_data", st_data, regv[base_m]);
      end
      if (done_m) chk("R7 ptr_eq_top", 64'(store_ptr), 64'(top_ptr));
    end
  end

  // store acknowledge driven from the observed request
  always @(negedge clk) begin
    st_ack <= st_req && (($urandom % 100) < ack_pct);
  end

  task automatic do_load(logic [31:0] p, int n, int b);
    @(negedge clk);
    ld_en <= 1'b1; ld_ptr <= p; ld_cnt <= CNT_W'(n); ld_base <= IDX_W'(b);
    @(negedge clk);
    ld_en <= 1'b0;
  endtask

  task automatic do_flush(string tag);
    int w = 0;
    @(negedge clk);
    flush_cmd <= 1'b1;
    @(negedge clk);
    flush_cmd <= 1'b0;
    while (!done && w < 5000) begin
      @(negedge clk);
      w++;
    end
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL %s watchdog actual=no_done expected=done", tag);
    end
  endtask

  initial begin
    for (int i = 0; i < NPHYS; i++) begin
      regv[i] = {32'hA5000000 + 32'(i), 32'(i * 7919)};
      natv[i] = ((i * 5) % 3) == 1;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 st_req", 64'(st_req), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 store_ptr", 64'(store_ptr), 64'd0);
    chk("R1 dirty_cnt", 64'(dirty_cnt), 64'd0);
    chk("R1 nat_acc", nat_acc, 64'd0);
    @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    cmp_on = 1;

    // R2 load, misaligned low bits dropped
    do_load(32'h0000_1005, 5, 10);
    chk("R2 load_ptr", 64'(store_ptr), 64'h1000);
    chk("R2 load_cnt", 64'(dirty_cnt), 64'd5);
    do_flush("R3");

    // R6 crossing a collection slot from slot 60
    ack_pct = 100;
    do_load(32'h0000_2000 + 32'(60 * 8), 10, 40);
    do_flush("R6");

    // R7 last register at slot 62, collection still written
    ack_pct = 30;
    do_load(32'h0000_3000 + 32'(62 * 8), 1, 95);
    do_flush("R7");
    chk("R7 end_ptr", 64'(store_ptr), 64'h3000 + 64'(64 * 8));

    // R9 zero dirty count
    do_load(32'h0000_4000, 0, 3);
    @(negedge clk);
    flush_cmd <= 1'b1;
    @(negedge clk);
    flush_cmd <= 1'b0;
    chk("R9 done", 64'(done), 64'd1);
    chk("R9 no_req", 64'(st_req), 64'd0);

    // R2 simultaneous flush and load: load dropped
    @(negedge clk);
    flush_cmd <= 1'b1; ld_en <= 1'b1; ld_ptr <= 32'h7000; ld_cnt <= 8'd9;
    @(negedge clk);
    flush_cmd <= 1'b0; ld_en <= 1'b0;
    chk("R2 load_dropped", 64'(store_ptr), 64'h4000);

    // R10 long run with base wrap and two collections; commands ignored while busy
    ack_pct = 50;
    do_load(32'h0001_0000 + 32'(5 * 8), 130, 90);
    @(negedge clk);
    flush_cmd <= 1'b1;
    @(negedge clk);
    flush_cmd <= 1'b0;
    repeat (4) @(negedge clk);
    ld_en <= 1'b1; ld_ptr <= 32'h0000_9000; ld_cnt <= 8'd1; flush_cmd <= 1'b1;
    @(negedge clk);
    ld_en <= 1'b0; flush_cmd <= 1'b0;
    chk("R10 busy_kept", 64'(busy), 64'd1);
    chk("R10 cnt_not_loaded", 64'(dirty_cnt), 64'(cnt_m));
    begin
      int w = 0;
      while (!done && w < 20000) begin @(negedge clk); w++; end
      checks++;
      if (!done) begin
        errors++;
        $display("FAIL R10 watchdog actual=no_done expected=done");
      end
    end
    chk("R7 final_cnt", 64'(dirty_cnt), 64'd0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule